// File: doc/BRIEF.md
# Segment Selector Load Validator

This unit checks a 16-bit selector that a protected-mode core wants to place in a segment register. A one-cycle start pulse brings in the selector, a flag that marks the target as the stack segment or as a data/extra segment, and the current privilege level. The unit also takes the base and byte limit of both descriptor tables. It first looks at the selector on its own. A null selector, or one whose descriptor would lie beyond the chosen table's limit, is resolved without reading memory. Any other selector causes the unit to read the 8-byte descriptor over a request/acknowledge port.

Once the descriptor arrives, the protection checks run in a fixed priority, which depends on the kind of register being loaded. The load ends in one of two ways. It may report a fault, with a vector and an error code taken from the selector. Otherwise it writes the selector, the decoded 32-bit base, the effective limit and the attribute bits into a shadow register. Exactly one completion pulse marks the end of each accepted start.

Top module: `seg_load_check`

## Requirements
- R1: The table is chosen by selector bit 2 (1 = local, 0 = global). The byte offset is the selector with bits [2:0] cleared. A non-null, in-bounds selector makes exactly one fetch, at address table base + offset.
- R2: If the byte offset exceeds the chosen table limit, the unit reports vector 13 with error code selector & 0xFFFC, and makes no fetch.
- R3: A null selector (bits [15:2] all zero) in a stack load reports vector 13 with error code 0. In a data load it commits the selector with base 0, limit 0 and attributes 0, and makes no fetch.
- R4: A stack load checks, in this priority: RPL equal to CPL, then a writable data descriptor (access bits [4:3] = 2'b10 and bit 1 set), then DPL (access [6:5]) equal to CPL. A failure reports vector 13 with code selector & 0xFFFC. If all of these pass, a clear present bit (access bit 7) reports vector 12.
- R5: A data load of a system descriptor (access bit 4 = 0) or of a code descriptor that cannot be read (bit 3 set, bit 1 clear) reports vector 13 with the masked-selector code.
- R6: For data descriptors and for non-conforming code descriptors (bit 2 clear), a data load reports vector 13 if RPL > DPL or CPL > DPL. Conforming readable code skips this test.
- R7: A data load whose descriptor passes R5 and R6 but is not present reports vector 11 with the masked-selector code.
- R8: On commit, base = {desc[63:56], desc[39:16]}. The 20-bit limit is {desc[51:48], desc[15:0]}; it is extended with 12'hFFF when desc[55] is set and zero-extended otherwise. Attributes = {desc[55:52], desc[47:40]}.
- R9: Each accepted start gives exactly one done pulse, carrying either the fault strobe or the commit strobe. A fault leaves the shadow register unchanged, and a start that arrives while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| selIn | input | 16 | Selector to load |
| stackLoad | input | 1 | 1 = stack segment target, 0 = data/extra target |
| curPriv | input | 2 | Current privilege level |
| globBase | input | 32 | Global table base address |
| globLimit | input | 16 | Global table byte limit |
| locBase | input | 32 | Local table base address |
| locLimit | input | 16 | Local table byte limit |
| memReq | output | 1 | Descriptor read request, held until acknowledged |
| memAddr | output | 32 | Descriptor read address |
| memAck | input | 1 | Read acknowledge, qualifies memData |
| memData | input | 64 | Descriptor returned by memory |
| done | output | 1 | One-cycle completion pulse |
| faultValid | output | 1 | Completion is a fault |
| faultVector | output | 8 | Fault vector (11, 12 or 13) |
| faultCode | output | 16 | Fault error code |
| commitValid | output | 1 | Completion is a commit |
| shadowSel | output | 16 | Committed selector |
| shadowBase | output | 32 | Committed base |
| shadowLimit | output | 32 | Committed effective limit |
| shadowAttr | output | 12 | Committed flags nibble and access byte |

## Verification
The hardest outcomes to reach are those that depend on the check priority. In these cases a descriptor breaks several rules at once and only the first in the order may appear. Examples are a stack load with a mismatched RPL and a clear present bit, and a data load where a conforming code segment must not trigger the privilege test. The stimulus builds descriptors that break two rules at the same time and changes CPL and RPL around each DPL. The memory model also delays its acknowledge, so the request has to be held. During one load a second start is pulsed while the first is still in progress.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;

  typedef struct packed {
    logic capture;
    logic descLatch;
    logic commitEn;
    logic faultEn;
  } ctrlStrobe_t;

  typedef struct packed {
    logic isNull;
    logic preFault;
    logic anyFault;
  } chkStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FETCH = 2'd2,
    ST_EVAL  = 2'd3
  } loadState_t;
endpackage

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_load_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  chkStatus_t  status,
  output logic        memReq,
  output ctrlStrobe_t strobe
);
  loadState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext      = ST_PRE;
        end
      end
      ST_PRE: begin
        if (status.preFault) begin
          strobe.faultEn = 1'b1;
          stateNext      = ST_IDLE;
        end else if (status.isNull) begin
          strobe.commitEn = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memAck) begin
          strobe.descLatch = 1'b1;
          stateNext        = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (status.anyFault) strobe.faultEn  = 1'b1;
        else                 strobe.commitEn = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_FETCH);

  // R1: an outstanding request stays up until it is acknowledged
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R9: no result is produced while a fetch is still pending
  a_r9_no_result_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.faultEn || strobe.commitEn) |-> !memReq);

  // R9: a fresh load is only captured while idle
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !strobe.capture);

  // R2: a selector that fails the early checks is never fetched
  a_r2_prefault_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE) && status.preFault |=> !memReq);
endmodule

// File: rtl/seg_load_dp.sv
module seg_load_dp
  import seg_load_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16,
  parameter int DESC_W = 64,
  parameter int ATTR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  selIn,
  input  logic              stackLoad,
  input  logic [1:0]        curPriv,
  input  logic [ADDR_W-1:0] globBase,
  input  logic [TLIM_W-1:0] globLimit,
  input  logic [ADDR_W-1:0] locBase,
  input  logic [TLIM_W-1:0] locLimit,
  input  logic [DESC_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output chkStatus_t        status,
  output logic              done,
  output logic              faultValid,
  output logic [7:0]        faultVector,
  output logic [SEL_W-1:0]  faultCode,
  output logic              commitValid,
  output logic [SEL_W-1:0]  shadowSel,
  output logic [ADDR_W-1:0] shadowBase,
  output logic [31:0]       shadowLimit,
  output logic [ATTR_W-1:0] shadowAttr
);
  localparam int CMP_W = (TLIM_W > SEL_W) ? TLIM_W : SEL_W;

  logic [SEL_W-1:0]  selQ;
  logic              stackQ;
  logic [1:0]        cplQ;
  logic [ADDR_W-1:0] tBaseQ;
  logic [TLIM_W-1:0] tLimQ;
  logic [DESC_W-1:0] descQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      stackQ <= 1'b0;
      cplQ   <= '0;
      tBaseQ <= '0;
      tLimQ  <= '0;
      descQ  <= '0;
    end else begin
      if (strobe.capture) begin
        selQ   <= selIn;
        stackQ <= stackLoad;
        cplQ   <= curPriv;
        tBaseQ <= selIn[2] ? locBase  : globBase;
        tLimQ  <= selIn[2] ? locLimit : globLimit;
      end
      if (strobe.descLatch) descQ <= memData;
    end
  end

  // selector fields
  logic [SEL_W-1:0] byteOffset;
  logic [SEL_W-1:0] maskCode;
  logic [1:0]       rpl;
  logic             isNull;
  logic             outOfBounds;

  assign byteOffset  = {selQ[SEL_W-1:3], 3'b000};
  assign maskCode    = {selQ[SEL_W-1:2], 2'b00};
  assign rpl         = selQ[1:0];
  assign isNull      = (selQ[SEL_W-1:2] == '0);
  assign outOfBounds = CMP_W'(byteOffset) > CMP_W'(tLimQ);
  assign memAddr     = tBaseQ + ADDR_W'(byteOffset);

  // descriptor fields
  logic [7:0]  acc;
  logic [3:0]  flagNib;
  logic [1:0]  dpl;
  logic        present, nonSys, isExec, confDown, readWrite;
  logic [19:0] lim20;
  logic [31:0] effLimit;
  logic [31:0] descBase;

  assign acc       = descQ[47:40];
  assign flagNib   = descQ[55:52];
  assign present   = acc[7];
  assign dpl       = acc[6:5];
  assign nonSys    = acc[4];
  assign isExec    = acc[3];
  assign confDown  = acc[2];
  assign readWrite = acc[1];
  assign lim20     = {descQ[51:48], descQ[15:0]};
  assign effLimit  = flagNib[3] ? {lim20, 12'hFFF} : {12'h000, lim20};
  assign descBase  = {descQ[63:56], descQ[39:16]};

  // prioritized fault chain
  logic             chkFault;
  logic [7:0]       chkVec;
  logic [SEL_W-1:0] chkCode;

  always_comb begin
    chkFault = 1'b0;
    chkVec   = VEC_GP;
    chkCode  = maskCode;
    if (isNull) begin
      if (stackQ) begin
        chkFault = 1'b1;
        chkCode  = '0;
      end
    end else if (outOfBounds) begin
      chkFault = 1'b1;
    end else if (stackQ) begin
      if (rpl != cplQ)                            chkFault = 1'b1;
      else if (!(nonSys && !isExec && readWrite)) chkFault = 1'b1;
      else if (dpl != cplQ)                       chkFault = 1'b1;
      else if (!present) begin
        chkFault = 1'b1;
        chkVec   = VEC_SS;
      end
    end else begin
      if (!nonSys || (isExec && !readWrite)) chkFault = 1'b1;
      else if ((!isExec || !confDown) && ((rpl > dpl) || (cplQ > dpl)))
        chkFault = 1'b1;
      else if (!present) begin
        chkFault = 1'b1;
        chkVec   = VEC_NP;
      end
    end
  end

  assign status.isNull   = isNull;
  assign status.preFault = isNull ? stackQ : outOfBounds;
  assign status.anyFault = chkFault;

  // result and shadow registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      faultValid  <= 1'b0;
      commitValid <= 1'b0;
      faultVector <= '0;
      faultCode   <= '0;
      shadowSel   <= '0;
      shadowBase  <= '0;
      shadowLimit <= '0;
      shadowAttr  <= '0;
    end else begin
      done        <= strobe.faultEn | strobe.commitEn;
      faultValid  <= strobe.faultEn;
      commitValid <= strobe.commitEn;
      if (strobe.faultEn) begin
        faultVector <= chkVec;
        faultCode   <= chkCode;
      end
      if (strobe.commitEn) begin
        shadowSel <= selQ;
        if (isNull) begin
          shadowBase  <= '0;
          shadowLimit <= '0;
          shadowAttr  <= '0;
        end else begin
          shadowBase  <= ADDR_W'(descBase);
          shadowLimit <= effLimit;
          shadowAttr  <= ATTR_W'({flagNib, acc});
        end
      end
    end
  end

  // R9: one outcome per completion
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({faultValid, commitValid}));

  // R9: a fault leaves the shadow register untouched
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $stable(shadowSel) && $stable(shadowBase) &&
                   $stable(shadowLimit) && $stable(shadowAttr));

  // R8: a page-granular commit always ends in a full page of limit
  a_r8_gran_fill: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && shadowAttr[ATTR_W-1] |-> shadowLimit[11:0] == 12'hFFF);

  // R4: the stack fault vector is only reported for stack loads
  a_r4_ss_vector: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && faultVector == VEC_SS |-> stackQ);

  // R7: the not-present vector is only reported for data loads
  a_r7_np_vector: assert property (@(posedge clk) disable iff (!rstN)
    faultValid && faultVector == VEC_NP |-> !stackQ);
endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_load_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16,
  parameter int DESC_W = 64,
  parameter int ATTR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEL_W-1:0]  selIn,
  input  logic              stackLoad,
  input  logic [1:0]        curPriv,
  input  logic [ADDR_W-1:0] globBase,
  input  logic [TLIM_W-1:0] globLimit,
  input  logic [ADDR_W-1:0] locBase,
  input  logic [TLIM_W-1:0] locLimit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DESC_W-1:0] memData,
  output logic              done,
  output logic              faultValid,
  output logic [7:0]        faultVector,
  output logic [SEL_W-1:0]  faultCode,
  output logic              commitValid,
  output logic [SEL_W-1:0]  shadowSel,
  output logic [ADDR_W-1:0] shadowBase,
  output logic [31:0]       shadowLimit,
  output logic [ATTR_W-1:0] shadowAttr
);
  ctrlStrobe_t strobe;
  chkStatus_t  status;

  seg_load_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .status (status),
    .memReq (memReq),
    .strobe (strobe)
  );

  seg_load_dp #(
    .SEL_W (SEL_W),
    .ADDR_W(ADDR_W),
    .TLIM_W(TLIM_W),
    .DESC_W(DESC_W),
    .ATTR_W(ATTR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .selIn      (selIn),
    .stackLoad  (stackLoad),
    .curPriv    (curPriv),
    .globBase   (globBase),
    .globLimit  (globLimit),
    .locBase    (locBase),
    .locLimit   (locLimit),
    .memData    (memData),
    .memAddr    (memAddr),
    .status     (status),
    .done       (done),
    .faultValid (faultValid),
    .faultVector(faultVector),
    .faultCode  (faultCode),
    .commitValid(commitValid),
    .shadowSel  (shadowSel),
    .shadowBase (shadowBase),
    .shadowLimit(shadowLimit),
    .shadowAttr (shadowAttr)
  );
endmodule

// File: tb/seg_load_check_bench.sv
module seg_load_check_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] selIn = '0;
  logic        stackLoad = 1'b0;
  logic [1:0]  curPriv = '0;
  logic [31:0] globBase = 32'h0000_1000;
  logic [15:0] globLimit = 16'h00FF;
  logic [31:0] locBase = 32'h0000_8000;
  logic [15:0] locLimit = 16'h003F;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [63:0] memData = '0;
  logic        done, faultValid, commitValid;
  logic [7:0]  faultVector;
  logic [15:0] faultCode, shadowSel;
  logic [31:0] shadowBase, shadowLimit;
  logic [11:0] shadowAttr;

  seg_load_check u_seg_load_check (
    .clk(clk), .rstN(rstN), .start(start), .selIn(selIn), .stackLoad(stackLoad),
    .curPriv(curPriv), .globBase(globBase), .globLimit(globLimit),
    .locBase(locBase), .locLimit(locLimit), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .done(done), .faultValid(faultValid),
    .faultVector(faultVector), .faultCode(faultCode), .commitValid(commitValid),
    .shadowSel(shadowSel), .shadowBase(shadowBase), .shadowLimit(shadowLimit),
    .shadowAttr(shadowAttr)
  );

  always #5 clk = ~clk;

  int vecs = 0;
  int fails = 0;
  bit finished = 1'b0;

  // memory model: acknowledges after a two-cycle wait
  logic [63:0] descMem = '0;
  logic [31:0] lastAddr = '0;
  int fetchCount = 0;
  int waitCnt = 0;
  int doneCount = 0;

  always @(negedge clk) begin
    if (done) doneCount++;
    if (memReq && !memAck) begin
      if (waitCnt < 1) waitCnt++;
      else begin
        waitCnt  = 0;
        memAck   = 1'b1;
        memData  = descMem;
        lastAddr = memAddr;
        fetchCount++;
      end
    end else begin
      memAck = 1'b0;
    end
  end

  // captured result of the last load
  logic        gotDone, gotFault, gotCommit;
  logic [7:0]  gotVec;
  logic [15:0] gotCode;

  function automatic logic [63:0] mkDesc(input logic [31:0] b, input logic [19:0] l,
                                         input logic [7:0] a, input logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:0], l[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runLoad(input logic [15:0] sel, input logic stk, input logic [1:0] cpl,
                         input logic [63:0] d);
    descMem = d;
    @(negedge clk);
    selIn = sel; stackLoad = stk; curPriv = cpl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDone = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        gotDone = 1'b1;
        break;
      end
      @(negedge clk);
    end
    gotFault = faultValid; gotCommit = commitValid;
    gotVec = faultVector; gotCode = faultCode;
  endtask

  task automatic expectFault(input string tag, input logic [7:0] v, input logic [15:0] c);
    chk({tag, " done"}, gotDone, 1);
    chk({tag, " fault"}, {gotFault, gotCommit}, 2'b10);
    chk({tag, " vector"}, gotVec, v);
    chk({tag, " code"}, gotCode, c);
  endtask

  task automatic testReset();
    chk("R9 reset done", done, 0);
    chk("R1 reset memReq", memReq, 0);
    chk("R8 reset shadow", {shadowSel, shadowBase}, 0);
  endtask

  task automatic testDataCommit();
    int f0 = fetchCount;
    runLoad(16'h0010, 1'b0, 2'd0, mkDesc(32'h1234_5678, 20'hABCDE, 8'h92, 4'b0100));
    chk("R9 commit strobe", {gotFault, gotCommit}, 2'b01);
    chk("R1 fetch address global", lastAddr, 32'h0000_1010);
    chk("R1 single fetch", fetchCount - f0, 1);
    chk("R8 base", shadowBase, 32'h1234_5678);
    chk("R8 byte limit", shadowLimit, 32'h000A_BCDE);
    chk("R8 attr", shadowAttr, 12'h492);
    chk("R8 sel", shadowSel, 16'h0010);
  endtask

  task automatic testLocalGran();
    runLoad(16'h001C, 1'b0, 2'd0, mkDesc(32'hCAFE_0000, 20'h00012, 8'h93, 4'b1100));
    chk("R1 fetch address local", lastAddr, 32'h0000_8018);
    chk("R8 page limit", shadowLimit, 32'h0001_2FFF);
    chk("R8 attr gran", shadowAttr, 12'hC93);
  endtask

  task automatic testBounds();
    int f0 = fetchCount;
    logic [15:0] prevSel = shadowSel;
    runLoad(16'h0108, 1'b0, 2'd0, 64'h0);
    expectFault("R2 global bounds", 8'd13, 16'h0108);
    chk("R2 no fetch", fetchCount - f0, 0);
    chk("R9 shadow kept on fault", shadowSel, prevSel);
    runLoad(16'h0047, 1'b1, 2'd3, 64'h0);
    expectFault("R2 local bounds", 8'd13, 16'h0044);
    chk("R2 no fetch local", fetchCount - f0, 0);
    // offset equal to limit boundary: 0x38 <= 0x3F passes
    runLoad(16'h003C, 1'b0, 2'd0, mkDesc(32'h0, 20'h1, 8'h92, 4'b0000));
    chk("R2 last entry accepted", gotCommit, 1);
  endtask

  task automatic testNull();
    int f0 = fetchCount;
    runLoad(16'h0003, 1'b1, 2'd3, 64'h0);
    expectFault("R3 null stack", 8'd13, 16'h0000);
    runLoad(16'h0002, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 null data commit", {gotFault, gotCommit}, 2'b01);
    chk("R3 null data shadow", {shadowSel, shadowBase, shadowLimit, 4'h0, shadowAttr},
        {16'h0002, 32'h0, 32'h0, 16'h0});
    chk("R3 null no fetch", fetchCount - f0, 0);
  endtask

  task automatic testStack();
    runLoad(16'h0010, 1'b1, 2'd0, mkDesc(32'h0000_2000, 20'hFFFF, 8'h92, 4'b0100));
    chk("R4 stack good commit", gotCommit, 1);
    runLoad(16'h0011, 1'b1, 2'd0, mkDesc(32'h0, 20'h0, 8'h12, 4'b0000));
    expectFault("R4 rpl mismatch beats present", 8'd13, 16'h0010);
    runLoad(16'h0010, 1'b1, 2'd0, mkDesc(32'h0, 20'h0, 8'h90, 4'b0000));
    expectFault("R4 read-only data", 8'd13, 16'h0010);
    runLoad(16'h0010, 1'b1, 2'd0, mkDesc(32'h0, 20'h0, 8'h9A, 4'b0000));
    expectFault("R4 code as stack", 8'd13, 16'h0010);
    runLoad(16'h0010, 1'b1, 2'd0, mkDesc(32'h0, 20'h0, 8'hB2, 4'b0000));
    expectFault("R4 dpl mismatch", 8'd13, 16'h0010);
    runLoad(16'h0012, 1'b1, 2'd2, mkDesc(32'h0, 20'h0, 8'h52, 4'b0000));
    expectFault("R4 not present", 8'd12, 16'h0010);
  endtask

  task automatic testData();
    runLoad(16'h0018, 1'b0, 2'd0, mkDesc(32'h0, 20'h0, 8'h82, 4'b0000));
    expectFault("R5 system desc", 8'd13, 16'h0018);
    runLoad(16'h0018, 1'b0, 2'd0, mkDesc(32'h0, 20'h0, 8'h98, 4'b0000));
    expectFault("R5 execute-only", 8'd13, 16'h0018);
    runLoad(16'h0018, 1'b0, 2'd0, mkDesc(32'h0, 20'h0, 8'h9A, 4'b0000));
    chk("R5 readable code ok", gotCommit, 1);
    runLoad(16'h001B, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'h92, 4'b0000));
    expectFault("R6 rpl over dpl", 8'd13, 16'h0018);
    runLoad(16'h0018, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'hB2, 4'b0000));
    expectFault("R6 cpl over dpl", 8'd13, 16'h0018);
    runLoad(16'h001B, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'h9A, 4'b0000));
    expectFault("R6 nonconforming code", 8'd13, 16'h0018);
    runLoad(16'h001B, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'h9E, 4'b0000));
    chk("R6 conforming skips", gotCommit, 1);
    runLoad(16'h001B, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'h72, 4'b0000));
    expectFault("R7 not present", 8'd11, 16'h0018);
    runLoad(16'h001B, 1'b0, 2'd3, mkDesc(32'h0, 20'h0, 8'h12, 4'b0000));
    expectFault("R7 priv before present", 8'd13, 16'h0018);
  endtask

  task automatic testBusyStart();
    int d0;
    descMem = mkDesc(32'h5555_0000, 20'h10, 8'h92, 4'b0000);
    @(negedge clk);
    d0 = doneCount;
    selIn = 16'h0020; stackLoad = 1'b0; curPriv = 2'd0; start = 1'b1;
    @(negedge clk);
    selIn = 16'h0028;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9 one done per start", doneCount - d0, 1);
    chk("R9 busy start ignored", shadowSel, 16'h0020);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDataCommit();
    testLocalGran();
    testBounds();
    testNull();
    testStack();
    testData();
    testBusyStart();
    finish();
  end
endmodule